// File: doc/BRIEF.md
# Encoder Counter with Sticky Overflow Flag

This block is a 16-bit up/down position counter with overflow detection, the kind that sits at the core of an encoder timer. It runs on the peripheral clock and moves one step only on cycles where a synchronous count enable is high. A direction input picks incrementing or decrementing. When an increment is taken while the counter holds its all-ones value, the counter wraps to zero. In that same clock the block fires a one-cycle overflow interrupt and sets a sticky overflow status flag.

The flag stays set until one of three clear sources acts:
- a write of 1 to a clear command bit;
- a software start trigger issued while the timer enable is low;
- an external simultaneous-start input held high.

If a clear and a new overflow land in the same cycle, the overflow wins. Decrementing past zero wraps to all-ones silently.

The flag is held by a two-state machine:
- `OVF_IDLE` means no overflow is pending.
- `OVF_PENDING` means an overflow has been latched.
- The transition *set* (`OVF_IDLE`/`OVF_PENDING` to `OVF_PENDING`) is taken on an up-wrap.
- The transition *clear* (`OVF_PENDING` to `OVF_IDLE`) is taken on any clear request without an up-wrap.
- Otherwise each state holds.

Top module: `enc_ovf_counter`

## Requirements
- R1: A synchronous reset (`rst`=1 at a clock edge) sets the counter to 0x0000, clears the flag and keeps the interrupt at 0.
- R2: On a clock with `cnt_en`=0 the counter keeps its value.
- R3: On a clock with `cnt_en`=1 and `dir_up`=1 the counter increases by one.
- R4: On a clock with `cnt_en`=1 and `dir_up`=0 the counter decreases by one. A step from 0x0000 gives 0xFFFF and neither sets the flag nor raises the interrupt.
- R5: An up step taken at 0xFFFF makes the counter 0x0000. In the same clock `ovf_irq` goes to 1 and `ovf_flag` goes to 1.
- R6: `ovf_irq` is high for exactly one clock per wrap.
- R7: Once set, `ovf_flag` remains 1 while no clear source is active.
- R8: A clock with `clr_wr`=1 and `clr_wdata`=1 clears the flag.
- R9: A clock with `clr_wr`=1 and `clr_wdata`=0 leaves the flag unchanged, and `clr_rd` always reads 0.
- R10: `sw_start`=1 clears the flag when `tmr_en`=0 and has no effect on the flag when `tmr_en`=1.
- R11: `ext_start`=1 at a clock edge clears the flag.
- R12: When an up-wrap and any clear source occur in the same clock, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count-clock enable, one step per high cycle |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| tmr_en | input | 1 | Timer enable status |
| sw_start | input | 1 | Software start trigger |
| ext_start | input | 1 | External simultaneous-start input, level sensitive |
| clr_wr | input | 1 | Write strobe of the clear command bit |
| clr_wdata | input | 1 | Data written to the clear command bit |
| cnt | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow status |
| ovf_irq | output | 1 | One-cycle overflow interrupt |
| clr_rd | output | 1 | Read-back of the clear command bit |

## Verification
The counter is driven through idle, up, down and wrap patterns:
- Idle cycles separate holding from stepping.
- A down pass across zero separates the silent downward wrap from the flagged upward one.
- Increments up to the all-ones value pin down the exact clock of the wrap and the one-cycle interrupt.

The flag is then set repeatedly and cleared by each source in turn. The stimulus also includes:
- a zero write to the clear bit;
- a start trigger with the timer running;
- a clear in the very clock of a wrap.

Together these tell the effective clear paths from the ignored ones and show the set priority.

// File: rtl/enc_ovf_pkg.sv
package enc_ovf_pkg;
    // Flag holder states
    typedef enum logic {
        OVF_IDLE    = 1'b0,
        OVF_PENDING = 1'b1
    } ovf_state_e;
endpackage

// File: rtl/enc_step_counter.sv
module enc_step_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         dir_up,
    output logic [W-1:0] cnt,
    output logic         wrap_up
);
    localparam logic [W-1:0] CNT_MAX  = {W{1'b1}};
    localparam logic [W-1:0] CNT_ZERO = '0;
    localparam logic [W-1:0] CNT_ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    // Up-wrap: an increment taken at the all-ones value
    assign wrap_up = cnt_en && dir_up && (cnt_q == CNT_MAX);

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_en) begin
            if (dir_up) cnt_d = cnt_q + CNT_ONE;
            else        cnt_d = cnt_q - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= CNT_ZERO;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(cnt));
    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && dir_up) |=> (cnt == $past(cnt) + CNT_ONE));
    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !dir_up) |=> (cnt == $past(cnt) - CNT_ONE));
    // R4
    no_down_wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !dir_up |-> !wrap_up);
    // R1
    cnt_reset_chk: assert property (@(posedge clk)
        rst |=> (cnt == CNT_ZERO));
endmodule

// File: rtl/enc_clr_decode.sv
module enc_clr_decode (
    input  logic clr_wr,
    input  logic clr_wdata,
    input  logic sw_start,
    input  logic tmr_en,
    input  logic ext_start,
    output logic clr_req,
    output logic clr_rd
);
    logic clr_by_cmd;
    logic clr_by_start;
    logic clr_by_ext;

    // Only a written 1 counts; a written 0 is ignored
    assign clr_by_cmd   = clr_wr && clr_wdata;
    // Start trigger clears only while the timer is stopped
    assign clr_by_start = sw_start && !tmr_en;
    // Level-sensitive external start
    assign clr_by_ext   = ext_start;

    assign clr_req = clr_by_cmd || clr_by_start || clr_by_ext;

    // The command bit is write-only in effect: reads return 0
    assign clr_rd = 1'b0;
endmodule

// File: rtl/enc_ovf_fsm.sv
module enc_ovf_fsm
    import enc_ovf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wrap_up,
    input  logic clr_req,
    output logic ovf_flag,
    output logic ovf_irq
);
    ovf_state_e state_q;
    ovf_state_e state_d;
    logic       irq_q;

    // Next state: set has priority over clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_IDLE: begin
                if (wrap_up) state_d = OVF_PENDING;
            end
            OVF_PENDING: begin
                if (wrap_up)      state_d = OVF_PENDING;
                else if (clr_req) state_d = OVF_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= OVF_IDLE;
        else     state_q <= state_d;
    end

    // Output register: interrupt aligned with the wrap
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= wrap_up;
    end

    assign ovf_flag = (state_q == OVF_PENDING);
    assign ovf_irq  = irq_q;

    // R5
    wrap_sets_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_up |=> (ovf_irq && ovf_flag));
    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap_up |=> !ovf_irq);
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!wrap_up && !clr_req) |=> $stable(ovf_flag));
    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !wrap_up) |=> !ovf_flag);
    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && wrap_up) |=> ovf_flag);
    // R1
    flag_reset_chk: assert property (@(posedge clk)
        rst |=> (!ovf_flag && !ovf_irq));
endmodule

// File: rtl/enc_ovf_counter.sv
module enc_ovf_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             dir_up,
    input  logic             tmr_en,
    input  logic             sw_start,
    input  logic             ext_start,
    input  logic             clr_wr,
    input  logic             clr_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_flag,
    output logic             ovf_irq,
    output logic             clr_rd
);
    logic wrap_up;
    logic clr_req;

    enc_step_counter #(.W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .dir_up  (dir_up),
        .cnt     (cnt),
        .wrap_up (wrap_up)
    );

    enc_clr_decode u_clr (
        .clr_wr    (clr_wr),
        .clr_wdata (clr_wdata),
        .sw_start  (sw_start),
        .tmr_en    (tmr_en),
        .ext_start (ext_start),
        .clr_req   (clr_req),
        .clr_rd    (clr_rd)
    );

    enc_ovf_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wrap_up  (wrap_up),
        .clr_req  (clr_req),
        .ovf_flag (ovf_flag),
        .ovf_irq  (ovf_irq)
    );

    // R10
    start_while_running_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_start && tmr_en && !ext_start && !(clr_wr && clr_wdata)) |=>
        (ovf_flag == ($past(ovf_flag) || $past(wrap_up))));
    // R11
    ext_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_start && !wrap_up) |=> !ovf_flag);
endmodule

// File: tb/enc_ovf_counter_bench.sv
module enc_ovf_counter_bench;
    typedef struct packed {
        logic [15:0] cnt;
        logic        flag;
        logic        irq;
        logic [7:0]  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0, dir_up = 1'b0, tmr_en = 1'b0;
    logic        sw_start = 1'b0, ext_start = 1'b0;
    logic        clr_wr = 1'b0, clr_wdata = 1'b0;
    logic [15:0] cnt;
    logic        ovf_flag, ovf_irq, clr_rd;

    exp_t        sb_q[$];
    int          vectors = 0;
    int          miscompares = 0;
    logic [15:0] m_cnt = 16'h0000;
    logic        m_flag = 1'b0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    enc_ovf_counter u_enc_ovf_counter (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_up(dir_up),
        .tmr_en(tmr_en), .sw_start(sw_start), .ext_start(ext_start),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .cnt(cnt), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq), .clr_rd(clr_rd)
    );

    // Driver: applies one clock of stimulus and queues the expected outputs
    task automatic step(input logic r, input logic en, input logic up,
                        input logic wr, input logic wd, input logic st,
                        input logic te, input logic ex, input int req);
        exp_t e;
        logic wrap, clr;
        @(negedge clk);
        rst = r; cnt_en = en; dir_up = up; clr_wr = wr; clr_wdata = wd;
        sw_start = st; tmr_en = te; ext_start = ex;
        wrap = en && up && (m_cnt == 16'hFFFF);
        clr  = (wr && wd) || (st && !te) || ex;
        if (r) begin
            m_cnt = 16'h0000; m_flag = 1'b0; wrap = 1'b0;
        end else begin
            if (en) m_cnt = up ? m_cnt + 16'd1 : m_cnt - 16'd1;
            if (wrap)     m_flag = 1'b1;
            else if (clr) m_flag = 1'b0;
        end
        e.cnt = m_cnt; e.flag = m_flag; e.irq = wrap; e.req = 8'(req);
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n, input int req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1, 0, req);
    endtask

    task automatic down(input int n, input int req);
        for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0, 0, 1, 0, req);
    endtask

    task automatic up(input int n, input int req);
        for (int i = 0; i < n; i++) step(0, 1, 1, 0, 0, 0, 1, 0, req);
    endtask

    // Monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                vectors++;
                if (cnt !== e.cnt || ovf_flag !== e.flag || ovf_irq !== e.irq
                    || clr_rd !== 1'b0) begin
                    miscompares++;
                    $display("FAIL R%0d: cnt=%h flag=%b irq=%b rd=%b expected cnt=%h flag=%b irq=%b rd=0",
                             e.req, cnt, ovf_flag, ovf_irq, clr_rd,
                             e.cnt, e.flag, e.irq);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1, 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 1, 1, 0, 0, 0, 0, 0, 1);
        // R2: hold with enable low
        idle(3, 2);
        // R3: increments
        up(5, 3);
        // R4: decrement through zero, no flag, no interrupt
        down(7, 4);
        // R5: FFFE -> FFFF -> wrap to 0000 with interrupt and flag
        up(2, 5);
        // R6: interrupt gone next clock; R7: flag stays
        idle(1, 6);
        up(3, 7);
        idle(2, 7);
        // R9: writing 0 to clear bit is ignored
        step(0, 0, 0, 1, 0, 0, 1, 0, 9);
        idle(1, 9);
        // R8: writing 1 clears
        step(0, 0, 0, 1, 1, 0, 1, 0, 8);
        idle(1, 8);
        // rearm: reach FFFF by counting down, then wrap
        down(4, 4);
        up(1, 5);
        // R10: start with timer running does nothing, stopped clears
        step(0, 0, 0, 0, 0, 1, 1, 0, 10);
        idle(1, 10);
        step(0, 0, 0, 0, 0, 1, 0, 0, 10);
        idle(1, 10);
        // R11: external start clears
        down(1, 4);
        up(1, 5);
        step(0, 0, 0, 0, 0, 0, 1, 1, 11);
        step(0, 1, 1, 0, 0, 0, 1, 1, 11);
        idle(1, 11);
        // R12: wrap together with each clear source
        down(2, 4);
        step(0, 1, 1, 1, 1, 0, 1, 0, 12);
        down(1, 4);
        step(0, 1, 1, 0, 0, 1, 0, 0, 12);
        down(1, 4);
        step(0, 1, 1, 0, 0, 0, 1, 1, 12);
        idle(2, 7);
        // R1: reset mid-run clears flag and counter
        up(3, 3);
        step(1, 1, 1, 0, 0, 0, 1, 0, 1);
        idle(2, 1);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule